// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block models the read path of a multi-bank NOR flash array while its internal program/erase engine is busy. A host issues single-byte reads on a simple bus. When the addressed bank is idle, or belongs to a different bank than the running operation, the read returns stored array data. When the addressed bank is busy, the read returns a status byte instead. Bit 7 of that byte is a completion flag (polling bit) and bit 6 is a per-read alternating flag (toggle bit).

The host starts a program with `prog_i` (address and data on `addr_i`/`wdata_i`) or a block erase with `erase_i` (any address inside the block). Each operation lasts `OP_CYCLES` clock cycles. A running erase can be suspended with `suspend_i`, which takes effect `SUSP_LAT` cycles later, and continued with `resume_i`. When an operation ends, `done_o` pulses and the array is updated. A program can only clear bits. An erase sets the whole block to 8'hFF.

Top module: `flash_status_resp`

## Requirements
- R1: `rdata_o` is registered: it takes the result of a read in the cycle after `rd_i` is sampled, and otherwise holds its value. After reset every array byte reads 8'hFF and `done_o` is 0.
- R2: While a program, an erase or a pending suspend is active, a read of any address in the busy bank (bank = `addr_i[ADDR_W-1 -: BANK_W]`) returns a status byte whose bits 5..0 are 0.
- R3: During a program, status bit 7 is the inverse of bit 7 of the byte being programmed.
- R4: During an erase, including the pending part of a suspend request, status bit 7 is 0.
- R5: Status bit 6 is 0 on the first status read after an operation starts, and it inverts on every later status read, whatever address in the bank is read.
- R6: A read of a bank other than the busy one returns array data.
- R7: Suspend applies only to an erase. Status bit 7 stays 0 (and bit 6 keeps toggling) for `SUSP_LAT` cycles after the request. After that, reads inside the erased block (block = `addr_i[ADDR_W-1:BLK_W]`) return bit 7 = 1, with bit 6 frozen at the value of the last status read.
- R8: While suspended, reads in the busy bank but outside the erased block return array data.
- R9: `resume_i` returns a suspended erase to the running state. The erase keeps its remaining cycle count and reads return toggling status again.
- R10: `done_o` pulses for one cycle exactly `OP_CYCLES` cycles after the edge that accepted an uninterrupted start command. From then on, reads return array data.
- R11: A completed program stores the old byte AND the new byte.
- R12: A completed erase writes 8'hFF to every byte of the target block and leaves every other block unchanged.
- R13: `prog_i` and `erase_i` are ignored while an operation or suspend is in progress. `suspend_i` is ignored during a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address for reads and commands |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Data for a program command |
| prog_i | input | 1 | Start program at addr_i |
| erase_i | input | 1 | Start erase of the block containing addr_i |
| suspend_i | input | 1 | Request erase suspend |
| resume_i | input | 1 | Resume a suspended erase |
| rdata_o | output | 8 | Registered read data or status |
| done_o | output | 1 | One-cycle pulse when an operation completes |

## Verification
Each read result is due one edge after the edge that samples `rd_i`, so the bench raises the strobe at a falling edge and samples `rdata_o` at the next falling edge. The completion pulse is due exactly `OP_CYCLES` edges after the accepting edge: the bench counts falling edges from the command and requires `done_o` low on every one except the last. The suspend latency is checked in two steps. A read on the edge right after the request must still show bit 7 = 0. After more than `SUSP_LAT` idle cycles, reads must show bit 7 = 1 with a frozen bit 6.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_SPEND,
    ST_SUSP
  } op_state_e;
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  input  logic                    prog_en_i,
  input  logic [ADDR_W-1:0]       prog_addr_i,
  input  logic [7:0]              prog_data_i,
  input  logic                    erase_en_i,
  input  logic [ADDR_W-BLK_W-1:0] erase_blk_i
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int BLK_SIZE = 1 << BLK_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (erase_en_i) begin
      for (int j = 0; j < BLK_SIZE; j++) mem_q[{erase_blk_i, BLK_W'(j)}] <= 8'hFF;
    end else if (prog_en_i) begin
      mem_q[prog_addr_i] <= mem_q[prog_addr_i] & prog_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R12: the controller never commits both kinds of write in one cycle
  a_r12_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_en_i && erase_en_i));
endmodule

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OP_CYCLES = 40,
  parameter int SUSP_LAT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output op_state_e         state_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output logic              start_o,
  output logic              arr_prog_o,
  output logic              arr_erase_o,
  output logic              done_o
);
  localparam int CNT_W  = $clog2(OP_CYCLES + 1);
  localparam int SCNT_W = $clog2(SUSP_LAT + 1);

  op_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SCNT_W-1:0] scnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              done_q;
  logic              last_cyc;

  assign last_cyc    = (cnt_q == CNT_W'(1));
  assign start_o     = (st_q == ST_IDLE) && (prog_i || erase_i);
  assign arr_prog_o  = (st_q == ST_PROG) && last_cyc;
  assign arr_erase_o = (st_q == ST_ERASE) && last_cyc && !suspend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      scnt_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (prog_i) begin
            st_q   <= ST_PROG;
            addr_q <= addr_i;
            data_q <= wdata_i;
            cnt_q  <= CNT_W'(OP_CYCLES);
          end else if (erase_i) begin
            st_q   <= ST_ERASE;
            addr_q <= addr_i;
            cnt_q  <= CNT_W'(OP_CYCLES);
          end
        end
        ST_PROG: begin
          if (last_cyc) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ERASE: begin
          if (suspend_i) begin
            st_q   <= ST_SPEND;
            scnt_q <= SCNT_W'(SUSP_LAT);
          end else if (last_cyc) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_SPEND: begin
          if (scnt_q == SCNT_W'(1)) st_q <= ST_SUSP;
          else scnt_q <= scnt_q - 1'b1;
        end
        ST_SUSP: if (resume_i) st_q <= ST_ERASE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = st_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign done_o    = done_q;

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_IDLE));
  a_r9_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SPEND || st_q == ST_SUSP) |=> $stable(cnt_q));
  a_r13_op_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  parameter int BANK_W = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [ADDR_W-BLK_W-1:0] rd_blk_i,
  input  op_state_e               state_i,
  input  logic [ADDR_W-BLK_W-1:0] op_blk_i,
  input  logic                    op_b7_i,
  input  logic                    start_i,
  input  logic [7:0]              arr_data_i,
  output logic [7:0]              rdata_o
);
  localparam int BW = ADDR_W - BLK_W;

  logic bank_hit, blk_hit, active, stat_rd, susp_rd, poll_bit, tog_q;
  logic [7:0] rdata_q;

  assign bank_hit = rd_blk_i[BW-1 -: BANK_W] == op_blk_i[BW-1 -: BANK_W];
  assign blk_hit  = rd_blk_i == op_blk_i;
  assign active   = state_i inside {ST_PROG, ST_ERASE, ST_SPEND};
  assign stat_rd  = rd_i && active && bank_hit;
  assign susp_rd  = rd_i && (state_i == ST_SUSP) && blk_hit;
  assign poll_bit = (state_i == ST_PROG) ? ~op_b7_i : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (start_i) tog_q <= 1'b0;
    else if (stat_rd) tog_q <= ~tog_q;
  end

  // suspended reads show the last toggle value returned, i.e. ~tog_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (stat_rd) rdata_q <= {poll_bit, tog_q, 6'b0};
    else if (susp_rd) rdata_q <= {1'b1, ~tog_q, 6'b0};
    else if (rd_i) rdata_q <= arr_data_i;
  end

  assign rdata_o = rdata_q;

  a_r2_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> (rdata_o[5:0] == 6'b0));
  a_r3_prog_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && state_i == ST_PROG) |=> (rdata_o[7] != $past(op_b7_i)));
  a_r4_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && state_i != ST_PROG) |=> !rdata_o[7]);
  a_r5_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !start_i) |=> (tog_q != $past(tog_q)));
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_rd |=> (rdata_o[7] && $stable(tog_q)));
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BLK_W     = 4,
  parameter int BANK_W    = 1,
  parameter int OP_CYCLES = 40,
  parameter int SUSP_LAT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic [7:0]        rdata_o,
  output logic              done_o
);
  op_state_e         state;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_data, arr_data;
  logic              start, arr_prog, arr_erase;

  flash_op_ctrl #(
    .ADDR_W(ADDR_W), .OP_CYCLES(OP_CYCLES), .SUSP_LAT(SUSP_LAT)
  ) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .prog_i, .erase_i, .suspend_i, .resume_i,
    .state_o(state), .op_addr_o(op_addr), .op_data_o(op_data), .start_o(start),
    .arr_prog_o(arr_prog), .arr_erase_o(arr_erase), .done_o
  );

  flash_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i(addr_i), .rd_data_o(arr_data),
    .prog_en_i(arr_prog), .prog_addr_i(op_addr), .prog_data_i(op_data),
    .erase_en_i(arr_erase), .erase_blk_i(op_addr[ADDR_W-1:BLK_W])
  );

  flash_status_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BANK_W(BANK_W)) u_mux (
    .clk_i, .rst_ni, .rd_i,
    .rd_blk_i(addr_i[ADDR_W-1:BLK_W]), .state_i(state),
    .op_blk_i(op_addr[ADDR_W-1:BLK_W]), .op_b7_i(op_data[7]),
    .start_i(start), .arr_data_i(arr_data), .rdata_o
  );

  a_r6_other_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[ADDR_W-1 -: BANK_W] != op_addr[ADDR_W-1 -: BANK_W])
      |=> (rdata_o == $past(arr_data)));
endmodule

// File: tb/tb_flash_status_resp.sv
module tb_flash_status_resp;
  localparam int ADDR_W = 8, OPC = 40, SLAT = 4;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic rd = 0, prog = 0, erase = 0, susp = 0, resume = 0;
  logic [7:0] wdata = '0, rdata;
  logic done;
  int n_chk = 0, n_bad = 0, cyc = 0;

  flash_status_resp #(.ADDR_W(ADDR_W), .BLK_W(4), .BANK_W(1),
                      .OP_CYCLES(OPC), .SUSP_LAT(SLAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wdata_i(wdata),
    .prog_i(prog), .erase_i(erase), .suspend_i(susp), .resume_i(resume),
    .rdata_o(rdata), .done_o(done));

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=hung exp=finished");
        finish_run();
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic rd_byte(logic [ADDR_W-1:0] a, output logic [7:0] v);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0; v = rdata;
  endtask

  task automatic do_prog(logic [ADDR_W-1:0] a, logic [7:0] d);
    addr = a; wdata = d; prog = 1;
    @(negedge clk);
    prog = 0;
  endtask

  task automatic do_erase(logic [ADDR_W-1:0] a);
    addr = a; erase = 1;
    @(negedge clk);
    erase = 0;
  endtask

  task automatic wait_done(string req);
    int k = 0;
    while (!done && k < 500) begin @(negedge clk); k++; end
    chk(req, {7'b0, done}, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 done after reset", {7'b0, done}, 8'h00);
    rd_byte(8'h05, v); chk("R1 reset array", v, 8'hFF);
    rd_byte(8'hC3, v); chk("R1 reset array", v, 8'hFF);
  endtask

  task automatic t_prog_timing();
    logic [7:0] v;
    do_prog(8'h12, 8'h3C);
    for (int i = 1; i <= OPC; i++) begin
      @(negedge clk);
      chk("R10 done timing", {7'b0, done}, (i == OPC) ? 8'h01 : 8'h00);
    end
    @(negedge clk);
    chk("R10 done single pulse", {7'b0, done}, 8'h00);
    rd_byte(8'h12, v); chk("R10 data after program", v, 8'h3C);
    addr = 8'h12; @(negedge clk);
    chk("R1 output held", rdata, 8'h3C);
  endtask

  task automatic t_prog_status();
    logic [7:0] v;
    do_prog(8'h12, 8'hA5);
    rd_byte(8'h12, v); chk("R3 R5 first status", v, 8'h00);
    rd_byte(8'h30, v); chk("R5 toggle other addr", v, 8'h40);
    rd_byte(8'h12, v); chk("R2 R5 status again", v, 8'h00);
    rd_byte(8'h85, v); chk("R6 other bank", v, 8'hFF);
    do_prog(8'h50, 8'h00);
    do_erase(8'h60);
    addr = 8'h12; susp = 1; @(negedge clk); susp = 0;
    rd_byte(8'h12, v); chk("R13 suspend ignored in program", v, 8'h40);
    wait_done("R10 program completes");
    rd_byte(8'h12, v); chk("R11 AND store", v, 8'h24);
    rd_byte(8'h50, v); chk("R13 program ignored", v, 8'hFF);
    rd_byte(8'h62, v); chk("R13 erase ignored", v, 8'hFF);
  endtask

  task automatic t_prog_b7_zero_data();
    logic [7:0] v;
    do_prog(8'h25, 8'h11);
    rd_byte(8'h25, v); chk("R3 inverse of bit7=0", v, 8'h80);
    rd_byte(8'h25, v); chk("R3 R5 toggled", v, 8'hC0);
    wait_done("R10 program completes");
    rd_byte(8'h25, v); chk("R11 stored", v, 8'h11);
  endtask

  task automatic t_erase_suspend();
    logic [7:0] v;
    do_prog(8'h0F, 8'h77);
    wait_done("R10 program completes");
    do_erase(8'h17);
    rd_byte(8'h12, v); chk("R4 R5 erase status", v, 8'h00);
    rd_byte(8'h7F, v); chk("R4 R5 erase status", v, 8'h40);
    rd_byte(8'h12, v); chk("R4 erase status", v, 8'h00);
    rd_byte(8'h9A, v); chk("R6 other bank in erase", v, 8'hFF);
    addr = 8'h13; susp = 1; @(negedge clk); susp = 0;
    rd_byte(8'h13, v); chk("R7 pending still zero", v, 8'h40);
    rd_byte(8'h13, v); chk("R7 pending still zero", v, 8'h00);
    repeat (SLAT + 2) @(negedge clk);
    rd_byte(8'h13, v); chk("R7 suspended poll", v, 8'h80);
    rd_byte(8'h1E, v); chk("R7 frozen toggle", v, 8'h80);
    rd_byte(8'h25, v); chk("R8 outside block", v, 8'h11);
    rd_byte(8'h0F, v); chk("R8 outside block", v, 8'h77);
    resume = 1; @(negedge clk); resume = 0;
    rd_byte(8'h12, v); chk("R9 resumed status", v, 8'h40);
    rd_byte(8'h12, v); chk("R9 resumed toggles", v, 8'h00);
    wait_done("R9 erase completes");
    rd_byte(8'h12, v); chk("R12 block erased", v, 8'hFF);
    rd_byte(8'h1F, v); chk("R12 block erased", v, 8'hFF);
    rd_byte(8'h25, v); chk("R12 next block kept", v, 8'h11);
    rd_byte(8'h0F, v); chk("R12 prior block kept", v, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prog_timing();
    t_prog_status();
    t_prog_b7_zero_data();
    t_erase_suspend();
    finish_run();
  end
endmodule